// File: doc/BRIEF.md
# ADC Master Serial Readout Controller

This block is the serial master that reads out a 16-bit conversion result from a converter core. It drives a discontinuous serial clock, a serial data line carrying the result most significant bit first, a frame-valid sync strobe and a busy flag. The converter core is seen as a result word and three timing strobes: conversion start, conversion done (with the result alongside), and a per-step tick from the successive-approximation sequencer.

Two readout modes are chosen by a static input. In read-after mode, the frame starts when the conversion completes. The serial clock is paced by a programmable divider, and busy stays high until the last bit has gone out. In read-during mode, the result captured at the previous conversion done is shifted out while the next conversion runs. Each step tick produces one clock pulse. The pulses for the final steps are twice as long, to keep digital activity away from the late, slow-settling decisions. Clock and sync polarity can each be inverted by a static input.

Top module: `adc_ser_master`

## Requirements
- R1: While reset is asserted and after it is released, with no stimulus: sclk equals clk_inv, sync equals sync_inv, sdout is 0 and busy is 0.
- R2: A frame carries exactly 16 data bits, most significant first, with exactly one raw clock pulse per bit. The raw clock is sclk XOR clk_inv, and a pulse is a high phase of the raw clock. sdout changes only on a falling raw-clock edge and is stable for the whole high phase.
- R3: In read-after mode (rd_during = 0), the frame starts on the clock edge that samples conv_done. The half-period H is 2^div_sel system clocks (codes 0..3 give 1, 2, 4, 8). During cycle k of the frame (k = 0 in the cycle after that edge), the raw clock is high when (k mod 2H) >= H, and the current bit is k / 2H. The frame lasts 32H cycles.
- R4: In read-after mode, busy rises the cycle after conv_start. It stays high through the conversion and the whole frame, and it falls in the same cycle that the frame ends. conv_start itself launches no frame.
- R5: In read-during mode (rd_during = 1), the frame starts on the edge that samples conv_start. It carries the result captured at the most recent conv_done. Busy is high from conv_start until the cycle after conv_done, independent of the frame, and conv_done launches no frame.
- R6: In read-during mode, each step_tick sampled while the frame waits for its next bit starts one raw-clock high phase in the next cycle. The phase lasts H cycles for bits 0..11 and 2H cycles for bits 12..15. After it the clock returns low and the next bit is presented. A step_tick that arrives during a high phase is ignored.
- R7: The first read-during frame after reset carries the all-zero word.
- R8: clk_inv = 1 inverts sclk at all times, including idle. sync_inv = 1 inverts sync; sync is active-high when sync_inv = 0.
- R9: Outside a frame, the raw clock is low and sdout is 0. The frame ends on the 16th falling raw-clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_during | input | 1 | Static mode: 0 = read after conversion, 1 = read during next conversion |
| div_sel | input | 2 | Static half-period select, H = 2^div_sel clocks |
| clk_inv | input | 1 | Static serial clock inversion |
| sync_inv | input | 1 | Static sync inversion |
| conv_start | input | 1 | One-cycle conversion start pulse |
| conv_done | input | 1 | One-cycle conversion complete pulse, result valid with it |
| result | input | 16 | Conversion result word |
| step_tick | input | 1 | One-cycle pulse per conversion step |
| sclk | output | 1 | Serial clock |
| sdout | output | 1 | Serial data, MSB first |
| sync | output | 1 | Frame-valid strobe |
| busy | output | 1 | Conversion (and, in read-after mode, readout) in progress |

## Verification
The hardest condition to reach from the ports is a step tick that lands inside a long high phase of one of the last four read-during bits. At that point the pacer is counting down rather than waiting. The bench fires an extra tick on the first cycle of bit 13's pulse and then checks that the waveform is unchanged, cycle by cycle. The zero word of R7 is also reachable only once per reset, so the bench resets before every read-during run and reads the first frame before any conv_done.

// File: rtl/adc_ser_pkg.sv
`timescale 1ns/1ps
package adc_ser_pkg;

  // Pacer states: idle, low phase (timed), high phase (timed), waiting for a step tick
  typedef enum logic [1:0] {
    CK_IDLE = 2'd0,
    CK_LOW  = 2'd1,
    CK_HIGH = 2'd2,
    CK_WAIT = 2'd3
  } ck_state_e;

  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned DIV_W_DEF  = 2;
  localparam int unsigned LATE_DEF   = 4;

endpackage

// File: rtl/adc_ser_rst_sync.sv
`timescale 1ns/1ps
module adc_ser_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/adc_ser_conv_track.sv
`timescale 1ns/1ps
module adc_ser_conv_track #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_during,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] result,
  input  logic              frame_active,
  output logic              launch,
  output logic [WORD_W-1:0] launch_word,
  output logic              busy
);

  logic              conv_q, conv_d, conv_en;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              hold_en;

  // conversion-in-progress flag
  always_comb begin
    conv_en = conv_start | conv_done;
    conv_d  = conv_start;
  end

  // previous result, kept for read-during frames
  always_comb begin
    hold_en = conv_done;
    hold_d  = result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      hold_q <= '0;
    end else begin
      if (conv_en) conv_q <= conv_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  always_comb begin
    if (rd_during) begin
      launch      = conv_start;
      launch_word = hold_q;
      busy        = conv_q;
    end else begin
      launch      = conv_done;
      launch_word = result;
      busy        = conv_q | frame_active;
    end
  end

endmodule

// File: rtl/adc_ser_pacer.sv
`timescale 1ns/1ps
module adc_ser_pacer
  import adc_ser_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned LATE   = 4,
  localparam int unsigned CNT_W = $clog2(WORD_W),
  localparam int unsigned TMR_W = 1 << DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_during,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             launch,
  input  logic             step_tick,
  input  logic [CNT_W-1:0] bit_idx,
  output logic             load_stb,
  output logic             fall_stb,
  output logic             sclk_raw,
  output logic             active
);

  ck_state_e        st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic [TMR_W:0]   half_base;
  logic [TMR_W:0]   half_len;
  logic [TMR_W-1:0] reload;
  logic             late_bit;
  logic             last_bit;
  logic             tmr_zero;

  always_comb begin
    late_bit  = rd_during && (bit_idx >= CNT_W'(WORD_W - LATE));
    last_bit  = (bit_idx == CNT_W'(WORD_W - 1));
    half_base = (TMR_W+1)'(1) << div_sel;
    half_len  = late_bit ? (half_base << 1) : half_base;
    reload    = TMR_W'(half_len - (TMR_W+1)'(1));
    tmr_zero  = (tmr_q == '0);
  end

  always_comb begin
    st_d     = st_q;
    tmr_d    = tmr_q;
    tmr_en   = 1'b0;
    load_stb = 1'b0;
    fall_stb = 1'b0;
    unique case (st_q)
      CK_IDLE: begin
        if (launch) begin
          load_stb = 1'b1;
          if (rd_during) begin
            st_d = CK_WAIT;
          end else begin
            st_d   = CK_LOW;
            tmr_d  = reload;
            tmr_en = 1'b1;
          end
        end
      end
      CK_LOW: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          st_d  = CK_HIGH;
          tmr_d = reload;
        end else begin
          tmr_d = tmr_q - TMR_W'(1);
        end
      end
      CK_WAIT: begin
        if (step_tick) begin
          st_d   = CK_HIGH;
          tmr_d  = reload;
          tmr_en = 1'b1;
        end
      end
      CK_HIGH: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          fall_stb = 1'b1;
          if (last_bit) begin
            st_d = CK_IDLE;
          end else if (rd_during) begin
            st_d = CK_WAIT;
          end else begin
            st_d  = CK_LOW;
            tmr_d = reload;
          end
        end else begin
          tmr_d = tmr_q - TMR_W'(1);
        end
      end
      default: st_d = CK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CK_IDLE;
      tmr_q <= '0;
    end else begin
      st_q <= st_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign sclk_raw = (st_q == CK_HIGH);
  assign active   = (st_q != CK_IDLE);

endmodule

// File: rtl/adc_ser_shifter.sv
`timescale 1ns/1ps
module adc_ser_shifter #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift_stb,
  output logic              msb,
  output logic [CNT_W-1:0]  bit_idx
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sh_en;

  always_comb begin
    sh_en = load_stb | shift_stb;
    if (load_stb) begin
      sh_d  = load_word;
      cnt_d = '0;
    end else begin
      sh_d  = {sh_q[WORD_W-2:0], 1'b0};
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign msb     = sh_q[WORD_W-1];
  assign bit_idx = cnt_q;

endmodule

// File: rtl/adc_ser_master.sv
`timescale 1ns/1ps
module adc_ser_master
  import adc_ser_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned LATE   = LATE_DEF,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_during,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              clk_inv,
  input  logic              sync_inv,
  input  logic              conv_start,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] result,
  input  logic              step_tick,
  output logic              sclk,
  output logic              sdout,
  output logic              sync,
  output logic              busy
);

  logic              rst_sync_n;
  logic              launch;
  logic [WORD_W-1:0] launch_word;
  logic              load_stb;
  logic              fall_stb;
  logic              sclk_raw;
  logic              active;
  logic              msb;
  logic [CNT_W-1:0]  bit_idx;

  adc_ser_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_ser_conv_track #(.WORD_W(WORD_W)) u_track (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rd_during    (rd_during),
    .conv_start   (conv_start),
    .conv_done    (conv_done),
    .result       (result),
    .frame_active (active),
    .launch       (launch),
    .launch_word  (launch_word),
    .busy         (busy)
  );

  adc_ser_pacer #(.WORD_W(WORD_W), .DIV_W(DIV_W), .LATE(LATE)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rd_during (rd_during),
    .div_sel   (div_sel),
    .launch    (launch),
    .step_tick (step_tick),
    .bit_idx   (bit_idx),
    .load_stb  (load_stb),
    .fall_stb  (fall_stb),
    .sclk_raw  (sclk_raw),
    .active    (active)
  );

  adc_ser_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_stb  (load_stb),
    .load_word (launch_word),
    .shift_stb (fall_stb),
    .msb       (msb),
    .bit_idx   (bit_idx)
  );

  assign sclk  = sclk_raw ^ clk_inv;
  assign sync  = active ^ sync_inv;
  assign sdout = active & msb;

endmodule

// File: rtl/adc_ser_master_chk.sv
`timescale 1ns/1ps
module adc_ser_master_chk (
  input logic clk,
  input logic rst_ni,
  input logic rd_during,
  input logic clk_inv,
  input logic sync_inv,
  input logic conv_start,
  input logic conv_done,
  input logic sclk,
  input logic sdout,
  input logic sync,
  input logic busy
);

  logic raw_ck;
  logic in_frame;

  assign raw_ck   = sclk ^ clk_inv;
  assign in_frame = sync ^ sync_inv;

  AST_IDLE_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_frame |-> (!raw_ck && !sdout)); // R9

  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    (raw_ck && $past(raw_ck)) |-> $stable(sdout)); // R2

  AST_BUSY_COVERS_FRAME: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rd_during && in_frame) |-> busy); // R4

  AST_LAUNCH_ON_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rd_during && conv_done && !in_frame) |=> in_frame); // R3

  AST_LAUNCH_ON_START: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_during && conv_start && !in_frame) |=> in_frame); // R5

  AST_DURING_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_during && conv_done && !conv_start) |=> !busy); // R5

endmodule

bind adc_ser_master adc_ser_master_chk u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .rd_during  (rd_during),
  .clk_inv    (clk_inv),
  .sync_inv   (sync_inv),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .sclk       (sclk),
  .sdout      (sdout),
  .sync       (sync),
  .busy       (busy)
);

// File: tb/tb_adc_ser_master.sv
`timescale 1ns/1ps
module tb_adc_ser_master;

  logic        clk;
  logic        rst_n;
  logic        rd_during;
  logic [1:0]  div_sel;
  logic        clk_inv;
  logic        sync_inv;
  logic        conv_start;
  logic        conv_done;
  logic [15:0] result;
  logic        step_tick;
  logic        sclk, sdout, sync, busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  adc_ser_master dut (
    .clk(clk), .rst_n(rst_n), .rd_during(rd_during), .div_sel(div_sel),
    .clk_inv(clk_inv), .sync_inv(sync_inv), .conv_start(conv_start),
    .conv_done(conv_done), .result(result), .step_tick(step_tick),
    .sclk(sclk), .sdout(sdout), .sync(sync), .busy(busy)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  // compares {sclk, sdout, sync, busy}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {sclk, sdout, sync, busy};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: {sclk,sdout,sync,busy} got %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 in reset", {clk_inv, 1'b0, sync_inv, 1'b0});
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {clk_inv, 1'b0, sync_inv, 1'b0});
  endtask

  task automatic pulse_start();
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
  endtask

  task automatic pulse_done(input logic [15:0] w);
    conv_done = 1'b1;
    result    = w;
    @(negedge clk);
    conv_done = 1'b0;
    result    = 16'h0;
  endtask

  // read-after mode: one full conversion + frame, checked every cycle
  task automatic run_after(input logic [15:0] w);
    int h;
    h = 1 << div_sel;
    pulse_start();
    for (int c = 0; c < 3; c++) begin
      chk("R4 busy before done, no frame", {clk_inv, 1'b0, sync_inv, 1'b1});
      @(negedge clk);
    end
    pulse_done(w);
    for (int k = 0; k < 32 * h; k++) begin
      int b;
      logic rawc;
      b    = k / (2 * h);
      rawc = (k % (2 * h)) >= h;
      chk("R2 R3 R8 frame cycle", {rawc ^ clk_inv, w[15 - b], ~sync_inv, 1'b1});
      @(negedge clk);
    end
    chk("R4 R9 frame end", {clk_inv, 1'b0, sync_inv, 1'b0});
    @(negedge clk);
    chk("R9 idle after frame", {clk_inv, 1'b0, sync_inv, 1'b0});
  endtask

  // read-during mode: conv_start launches frame carrying w, ticks pace bits
  task automatic run_during(input logic [15:0] w, input logic [15:0] next_w, input int ign);
    int h;
    h = 1 << div_sel;
    pulse_start();
    for (int i = 0; i < 16; i++) begin
      int hl;
      hl = (i >= 12) ? 2 * h : h;
      chk("R5 R6 wait for tick", {clk_inv, w[15 - i], ~sync_inv, 1'b1});
      @(negedge clk);
      chk("R6 still waiting", {clk_inv, w[15 - i], ~sync_inv, 1'b1});
      step_tick = 1'b1;
      @(negedge clk);
      step_tick = 1'b0;
      for (int k = 0; k < hl; k++) begin
        chk(((i == 0) ? "R7 R6 pulse" : "R6 R8 pulse"), {~clk_inv, w[15 - i], ~sync_inv, 1'b1});
        step_tick = (k == 0) && (i == ign);
        @(negedge clk);
        step_tick = 1'b0;
      end
    end
    chk("R9 R6 frame over after 16 ticks", {clk_inv, 1'b0, sync_inv, 1'b1});
    @(negedge clk);
    pulse_done(next_w);
    chk("R5 busy drops on done", {clk_inv, 1'b0, sync_inv, 1'b0});
    @(negedge clk);
    chk("R5 done starts no frame", {clk_inv, 1'b0, sync_inv, 1'b0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; rd_during = 1'b0; div_sel = 2'd0; clk_inv = 1'b1; sync_inv = 1'b1;
    conv_start = 1'b0; conv_done = 1'b0; result = 16'h0; step_tick = 1'b0;
    do_reset();
    clk_inv = 1'b0; sync_inv = 1'b0;
    @(negedge clk);
    chk("R1 R8 idle normal polarity", 4'b0000);

    // read-after sweep: every divider code x every polarity pair x two words
    for (int d = 0; d < 4; d++) begin
      for (int p = 0; p < 4; p++) begin
        div_sel  = 2'(d);
        clk_inv  = p[0];
        sync_inv = p[1];
        @(negedge clk);
        chk("R8 R9 idle with polarity", {clk_inv, 1'b0, sync_inv, 1'b0});
        run_after(16'h8001 ^ 16'(d * 16'h1234) ^ 16'(p * 16'h0F0F));
        run_after(~(16'h4C3A + 16'(d * 7 + p)));
      end
    end
    run_after(16'hFFFF);
    run_after(16'h0000);

    // read-during sweep: reset first so the first frame is the zero word (R7)
    for (int d = 0; d < 4; d++) begin
      rd_during = 1'b1;
      div_sel   = 2'(d);
      clk_inv   = d[0];
      sync_inv  = d[1];
      do_reset();
      run_during(16'h0000, 16'hB6D1 ^ 16'(d), 99);
      run_during(16'hB6D1 ^ 16'(d), 16'h5A0F, 13);
      run_during(16'h5A0F, 16'h0000, 12);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule